// File: doc/BRIEF.md
# Gated Programmable Pixel Clock Divider

This block divides a fast input clock by one of nine fixed ratios, chosen through a 4-bit select field, and drives the result as a divided clock. The output has an even split between its low and high phases for every ratio, including the odd ones. It does this by stretching the low phase by half an input period with a copy of the phase signal taken on the falling edge.

An enable pin starts and stops the output, and a polarity bit sets which level of that pin counts as active. When the enable goes away, the current output period runs to its end and the output then stays high. When the enable comes back, a fresh period starts on an input-clock rising edge, so the output phase is tied to the input clock. The enable passes through a two-flop synchronizer, and those two flops are part of the restart delay.

A change of the ratio select takes effect only when the output is parked or at the boundary between two output periods. A period that is already running is never cut short or stretched by a select change.

Top module: `pixclk_gated_div`

## Requirements
- R1: Select codes 0 through 8 give divide ratios 3, 4, 5, 6, 8, 10, 12, 16 and 20 in that order. The output period is that many input-clock periods.
- R2: Select codes 9 through 15 divide by 4.
- R3: Each output period begins with a low phase and ends with a high phase. For a ratio M, each phase lasts M half-periods of the input clock, odd M included.
- R4: The enable is active high when the polarity bit is 1 and active low when it is 0. While the enable sits at its inactive level, the output stays high.
- R5: After the enable becomes active between two rising edges, the output stays high through the second rising edge. It falls on the third rising edge.
- R6: When the enable is removed, the output finishes the period in progress and then stays high.
- R7: A select change made during a running period does not alter that period. The new ratio applies from the next period on.
- R8: The asynchronous active-low reset forces the output high at once. After reset the block stays parked until the enable is active.
- R9: While the enable stays active, output periods follow one another with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 4 | Divide ratio select code |
| en_pol | input | 1 | Enable polarity: 1 active high, 0 active low |
| en_req | input | 1 | Output enable, asynchronous to nothing but sampled by clk_fast |
| clk_div | output | 1 | Divided clock output |

## Verification
The hardest situations to reach are a select change or an enable removal that lands inside a running period. Both must leave that period untouched, which the ports cannot show unless the event falls strictly between two period boundaries. To get there, the stimulus uses the largest ratio, starts the output, and changes the select or drops the enable half a cycle after the first falling edge. It then measures the low and high run lengths in input half-periods, so the difference between the old and new ratio, or a missing park, shows up as a run of the wrong length. The restart edge is pinned by sampling the output just before and just after the third rising edge that follows the enable.

// File: rtl/pcd_pkg.sv
`timescale 1ns/100ps
package pcd_pkg;
  parameter int unsigned SEL_W = 4;
  parameter int unsigned MOD_W = 5;

  typedef logic [MOD_W-1:0] mod_t;
  typedef logic [SEL_W-1:0] sel_t;

  // Select code to divide ratio; unlisted codes fall back to four.
  function automatic mod_t sel_to_mod(input sel_t sel);
    mod_t m;
    case (sel)
      4'd0:    m = mod_t'(3);
      4'd1:    m = mod_t'(4);
      4'd2:    m = mod_t'(5);
      4'd3:    m = mod_t'(6);
      4'd4:    m = mod_t'(8);
      4'd5:    m = mod_t'(10);
      4'd6:    m = mod_t'(12);
      4'd7:    m = mod_t'(16);
      4'd8:    m = mod_t'(20);
      default: m = mod_t'(4);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pcd_sync.sv
`timescale 1ns/100ps
module pcd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pol,
  input  logic en_req,
  output logic en_s
);
  logic act;
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign act = en_pol ? en_req : ~en_req;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = act;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign en_s = chain_q[STAGES-1];
endmodule

// File: rtl/pcd_seq.sv
`timescale 1ns/100ps
module pcd_seq
  import pcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  sel_t div_sel,
  output logic lo_phase,
  output logic odd_mode
);
  logic run_q, run_d;
  mod_t cnt_q, cnt_d;
  mod_t mod_q, mod_d;
  logic lo_q,  lo_d;
  logic at_end;

  assign at_end = (cnt_q == mod_t'(mod_q - 1'b1));

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    mod_d = mod_q;
    if (!run_q) begin
      // parked: track the select, start when enabled
      mod_d = sel_to_mod(div_sel);
      cnt_d = '0;
      if (en_s) run_d = 1'b1;
    end else if (at_end) begin
      cnt_d = '0;
      if (en_s) mod_d = sel_to_mod(div_sel);
      else      run_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    lo_d = run_d && (cnt_d < (mod_d >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      mod_q <= mod_t'(4);
      lo_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      mod_q <= mod_d;
      lo_q  <= lo_d;
    end
  end

  assign lo_phase = lo_q;
  assign odd_mode = mod_q[0];

  a_r1_legal_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    mod_q inside {5'd3, 5'd4, 5'd5, 5'd6, 5'd8, 5'd10, 5'd12, 5'd16, 5'd20});

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < mod_q));

  a_r7_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && cnt_q != '0) |-> $stable(mod_q));

  a_r6_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && !run_q) |-> ($past(cnt_q) == mod_t'($past(mod_q) - 1'b1)));

  a_r8_parked_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !lo_q);

  a_r5_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cnt_q == '0 && lo_q && $past(en_s)));
endmodule

// File: rtl/pcd_halfext.sv
`timescale 1ns/100ps
module pcd_halfext (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_phase,
  input  logic odd_mode,
  output logic clk_div
);
  logic lo_neg_q;

  // half-period delayed copy of the low phase
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) lo_neg_q <= 1'b0;
    else        lo_neg_q <= lo_phase;
  end

  assign clk_div = ~(lo_phase | (odd_mode & lo_neg_q));

  always_ff @(posedge clk) begin
    if (rst_n === 1'b0) begin
      a_r8_reset_high: assert (clk_div === 1'b1);
    end
  end

  a_r3_stretch_only_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (!odd_mode && !lo_phase) |-> clk_div);
endmodule

// File: rtl/pixclk_gated_div.sv
`timescale 1ns/100ps
module pixclk_gated_div
  import pcd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             en_pol,
  input  logic             en_req,
  output logic             clk_div
);
  logic en_s;
  logic lo_phase;
  logic odd_mode;

  pcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk_fast),
    .rst_n  (rst_n),
    .en_pol (en_pol),
    .en_req (en_req),
    .en_s   (en_s)
  );

  pcd_seq u_seq (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .en_s     (en_s),
    .div_sel  (div_sel),
    .lo_phase (lo_phase),
    .odd_mode (odd_mode)
  );

  pcd_halfext u_ext (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .lo_phase (lo_phase),
    .odd_mode (odd_mode),
    .clk_div  (clk_div)
  );
endmodule

// File: tb/pixclk_gated_div_test.sv
`timescale 1ns/100ps
module pixclk_gated_div_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] div_sel;
  logic       en_pol;
  logic       en_req;
  logic       clk_div;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int CAP = 100;
  localparam int NV  = 11;
  // {select code, polarity, expected ratio}
  localparam logic [9:0] VEC [NV] = '{
    {4'd0,  1'b0, 5'd3},
    {4'd1,  1'b1, 5'd4},
    {4'd2,  1'b0, 5'd5},
    {4'd3,  1'b1, 5'd6},
    {4'd4,  1'b0, 5'd8},
    {4'd5,  1'b1, 5'd10},
    {4'd6,  1'b0, 5'd12},
    {4'd7,  1'b1, 5'd16},
    {4'd8,  1'b0, 5'd20},
    {4'd12, 1'b1, 5'd4},
    {4'd15, 1'b0, 5'd4}
  };

  always #5 clk = ~clk;

  pixclk_gated_div uut (
    .clk_fast (clk),
    .rst_n    (rst_n),
    .div_sel  (div_sel),
    .en_pol   (en_pol),
    .en_req   (en_req),
    .clk_div  (clk_div)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // count consecutive half-period samples at level lvl
  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (clk_div === lvl && n < CAP) begin
      n++;
      #5;
    end
  endtask

  task automatic park(input logic [3:0] s, input logic p);
    @(posedge clk); #1;
    en_pol  = p;
    en_req  = ~p;
    div_sel = s;
    repeat (50) @(posedge clk);
    #2;
  endtask

  // enable; returns aligned to a half-slot sample point after the first fall
  task automatic launch(input logic p);
    @(posedge clk); #1;
    en_req = p;
    @(posedge clk);
    @(posedge clk);
    #7.5;
    chk(clk_div === 1'b1, "R5 high before third edge", int'(clk_div), 1);
    #5;
    chk(clk_div === 1'b0, "R5 falls on third edge", int'(clk_div), 0);
  endtask

  initial begin
    int n;
    rst_n = 1'b1; en_pol = 1'b0; en_req = 1'b1; div_sel = 4'd0;
    #1 rst_n = 1'b0;
    #2;
    chk(clk_div === 1'b1, "R8 reset output high", int'(clk_div), 1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #2;
    chk(clk_div === 1'b1, "R8 parked after reset", int'(clk_div), 1);

    // table of ratios and polarities
    for (int i = 0; i < NV; i++) begin
      logic [3:0] s;
      logic       p;
      int         m;
      s = VEC[i][9:6];
      p = VEC[i][5];
      m = int'(VEC[i][4:0]);
      park(s, p);
      chk(clk_div === 1'b1, "R4 inactive level parks", int'(clk_div), 1);
      launch(p);
      run_len(1'b0, n);
      chk(n == m, (s <= 4'd8) ? "R1 R3 low run" : "R2 R3 low run", n, m);
      run_len(1'b1, n);
      chk(n == m, (s <= 4'd8) ? "R1 R3 high run" : "R2 R3 high run", n, m);
      run_len(1'b0, n);
      chk(n == m, "R9 second low run", n, m);
      run_len(1'b1, n);
      chk(n == m, "R9 second high run", n, m);
    end

    // R6: drop enable inside the first period
    park(4'd8, 1'b1);
    launch(1'b1);
    #5;
    en_req = 1'b0;
    run_len(1'b0, n);
    chk(n == 19, "R6 period completes low", n, 19);
    run_len(1'b1, n);
    chk(n == CAP, "R6 parks high", n, CAP);

    // R7: select change inside a running period
    park(4'd8, 1'b0);
    launch(1'b0);
    #5;
    div_sel = 4'd0;
    run_len(1'b0, n);
    chk(n == 19, "R7 old ratio low", n, 19);
    run_len(1'b1, n);
    chk(n == 20, "R7 old ratio high", n, 20);
    run_len(1'b0, n);
    chk(n == 3, "R7 new ratio low", n, 3);
    run_len(1'b1, n);
    chk(n == 3, "R7 new ratio high", n, 3);

    // R8: reset during a low phase
    park(4'd8, 1'b1);
    launch(1'b1);
    #1 rst_n = 1'b0;
    #1;
    chk(clk_div === 1'b1, "R8 async reset forces high", int'(clk_div), 1);
    en_req = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #2;
    chk(clk_div === 1'b1, "R8 stays parked", int'(clk_div), 1);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule